// File: doc/BRIEF.md
# Shared-RAM Host Access Port

This block gives a host processor a byte-wide window into the private RAM of an attached coprocessor. A 16-bit RAM pointer is loaded one byte at a time through two pointer registers. A data register then reads or writes the byte the pointer names. With streaming turned on, every data access steps the pointer forward by one. The host can therefore move a whole firmware image in or out after loading the pointer once, and can compare an image by reading it back in the same way.

A control and status register sets the coprocessor's run and bypass modes and rings a doorbell toward it. The same register shows two interrupt causes raised from the coprocessor side. Both causes drive one host interrupt line. The host reads the register to see which cause fired, and clears a cause by writing a one to its bit. The RAM is an internal array of 2^RAM_AW bytes, indexed by the low RAM_AW bits of the pointer.

Top module: `shram_host_port`

## Requirements
- R1: After reset the pointer is 0x0000, every control and status bit is 0, and cp_run, cp_bypass, cp_doorbell and host_irq are low.
- R2: A write to register 0 replaces only pointer bits 7:0, and a write to register 1 replaces only bits 15:8. Reading register 0 or 1 returns the matching pointer byte. The RAM is indexed by the low RAM_AW bits of the pointer, so pointers that differ only above those bits name the same byte.
- R3: A write to register 2 stores the byte at the pointer. A read of register 2 returns the stored byte on hb_rdata in the cycle after the read strobe.
- R4: When control bit 1 (streaming) is set, each access to register 2 adds one to the pointer. When bit 1 is clear, the pointer does not change.
- R5: A streaming step from pointer 0xFFFF gives pointer 0x0000.
- R6: Register 3 is laid out as bit0 run, bit1 streaming, bit2 bypass, bit3 doorbell, bit4 cause A, bit5 cause B, with bits 7:6 reading as 0. A write loads bits 2:0, and cp_run and cp_bypass follow bits 0 and 2 in the next cycle.
- R7: Writing 1 to bit 3 sets cp_doorbell. Writing 0 to bit 3 leaves it unchanged. A pulse on cp_doorbell_ack clears it, except that a set from the host in the same cycle wins.
- R8: A pulse on cp_int0_set or cp_int1_set sets cause A or cause B. host_irq is high whenever either cause is set.
- R9: Writing 1 to bit 4 or bit 5 of register 3 clears that cause, and writing 0 leaves it set. A set pulse arriving in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_valid | input | 1 | Host access strobe, one cycle per access |
| hb_we | input | 1 | 1 = write, 0 = read |
| hb_reg | input | 2 | Register select: 0 pointer low, 1 pointer high, 2 data, 3 control/status |
| hb_wdata | input | DATA_W | Host write data |
| hb_rdata | output | DATA_W | Host read data, valid the cycle after a read strobe |
| cp_int0_set | input | 1 | Coprocessor pulse raising cause A |
| cp_int1_set | input | 1 | Coprocessor pulse raising cause B |
| cp_doorbell_ack | input | 1 | Coprocessor acknowledge of the doorbell |
| cp_run | output | 1 | Run enable to the coprocessor |
| cp_bypass | output | 1 | Bypass mode to the coprocessor |
| cp_doorbell | output | 1 | Doorbell interrupt to the coprocessor |
| host_irq | output | 1 | Shared host interrupt (cause A or cause B) |

## Verification
The data path is exercised with single bytes written at scattered pointers and read back after reloading the pointer each time. This separates storage faults from pointer-step faults. A 64-byte streamed write and read-back, followed by a readout of the pointer, shows whether each access steps the pointer exactly once. Two boundary probes are used: a write at a pointer above the RAM size that is read back through its low-bit alias, and a streamed access at 0xFFFF. The control register is tested with set and clear races on the doorbell and on both causes, which show whether the set or the clear has priority.

// File: rtl/shram_pkg.sv
package shram_pkg;
  typedef enum logic [1:0] {
    REG_PTR_LO = 2'd0,
    REG_PTR_HI = 2'd1,
    REG_DATA   = 2'd2,
    REG_CTRL   = 2'd3
  } hreg_e;

  localparam int CB_RUN    = 0;
  localparam int CB_STREAM = 1;
  localparam int CB_BYPASS = 2;
  localparam int CB_DBELL  = 3;
  localparam int CB_CAUSEA = 4;
  localparam int CB_CAUSEB = 5;
  localparam int CB_COUNT  = 6;
endpackage

// File: rtl/shram_ptr.sv
module shram_ptr #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_lo,
  input  logic                  ld_hi,
  input  logic                  step,
  input  logic [DATA_W-1:0]     din,
  output logic [2*DATA_W-1:0]   ptr
);
  localparam int PW = 2 * DATA_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (ld_lo) begin
      ptr[DATA_W-1:0] <= din;
    end else if (ld_hi) begin
      ptr[PW-1:DATA_W] <= din;
    end else if (step) begin
      ptr <= ptr + PW'(1);
    end
  end
endmodule

// File: rtl/shram_ram.sv
module shram_ram #(
  parameter int DATA_W = 8,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) q <= mem[idx];
  end
endmodule

// File: rtl/shram_ctrl.sv
module shram_ctrl
  import shram_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  input  logic              causea_set,
  input  logic              causeb_set,
  input  logic              dbell_ack,
  output logic [DATA_W-1:0] status
);
  logic run_q, stream_q, bypass_q, dbell_q, causea_q, causeb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      stream_q <= 1'b0;
      bypass_q <= 1'b0;
      dbell_q  <= 1'b0;
      causea_q <= 1'b0;
      causeb_q <= 1'b0;
    end else begin
      if (wr) begin
        run_q    <= din[CB_RUN];
        stream_q <= din[CB_STREAM];
        bypass_q <= din[CB_BYPASS];
      end
      if (wr && din[CB_DBELL])       dbell_q <= 1'b1;
      else if (dbell_ack)            dbell_q <= 1'b0;
      if (causea_set)                causea_q <= 1'b1;
      else if (wr && din[CB_CAUSEA]) causea_q <= 1'b0;
      if (causeb_set)                causeb_q <= 1'b1;
      else if (wr && din[CB_CAUSEB]) causeb_q <= 1'b0;
    end
  end

  always_comb begin
    status            = '0;
    status[CB_RUN]    = run_q;
    status[CB_STREAM] = stream_q;
    status[CB_BYPASS] = bypass_q;
    status[CB_DBELL]  = dbell_q;
    status[CB_CAUSEA] = causea_q;
    status[CB_CAUSEB] = causeb_q;
  end
endmodule

// File: rtl/shram_host_port.sv
module shram_host_port
  import shram_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hb_valid,
  input  logic              hb_we,
  input  logic [1:0]        hb_reg,
  input  logic [DATA_W-1:0] hb_wdata,
  output logic [DATA_W-1:0] hb_rdata,
  input  logic              cp_int0_set,
  input  logic              cp_int1_set,
  input  logic              cp_doorbell_ack,
  output logic              cp_run,
  output logic              cp_bypass,
  output logic              cp_doorbell,
  output logic              host_irq
);
  localparam int PW = 2 * DATA_W;

  logic [PW-1:0]     ptr;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] reg_q;
  logic              sel_ram_q;
  logic              wr_acc, rd_acc, data_acc;

  assign wr_acc   = hb_valid &  hb_we;
  assign rd_acc   = hb_valid & ~hb_we;
  assign data_acc = hb_valid & (hb_reg == REG_DATA);

  shram_ptr #(.DATA_W(DATA_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .ld_lo (wr_acc & (hb_reg == REG_PTR_LO)),
    .ld_hi (wr_acc & (hb_reg == REG_PTR_HI)),
    .step  (data_acc & status[CB_STREAM]),
    .din   (hb_wdata),
    .ptr   (ptr)
  );

  shram_ram #(.DATA_W(DATA_W), .AW(RAM_AW)) u_ram (
    .clk   (clk),
    .we    (data_acc & hb_we),
    .re    (data_acc & ~hb_we),
    .idx   (ptr[RAM_AW-1:0]),
    .wdata (hb_wdata),
    .q     (ram_q)
  );

  shram_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr         (wr_acc & (hb_reg == REG_CTRL)),
    .din        (hb_wdata),
    .causea_set (cp_int0_set),
    .causeb_set (cp_int1_set),
    .dbell_ack  (cp_doorbell_ack),
    .status     (status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      sel_ram_q <= 1'b0;
    end else if (rd_acc) begin
      sel_ram_q <= (hb_reg == REG_DATA);
      case (hb_reg)
        REG_PTR_LO: reg_q <= ptr[DATA_W-1:0];
        REG_PTR_HI: reg_q <= ptr[PW-1:DATA_W];
        REG_CTRL:   reg_q <= status;
        default:    reg_q <= '0;
      endcase
    end
  end

  assign hb_rdata    = sel_ram_q ? ram_q : reg_q;
  assign cp_run      = status[CB_RUN];
  assign cp_bypass   = status[CB_BYPASS];
  assign cp_doorbell = status[CB_DBELL];
  assign host_irq    = status[CB_CAUSEA] | status[CB_CAUSEB];
endmodule

// File: rtl/shram_host_port_chk.sv
module shram_host_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              hb_valid,
  input logic              hb_we,
  input logic [1:0]        hb_reg,
  input logic [DATA_W-1:0] hb_wdata,
  input logic              cp_int0_set,
  input logic              cp_int1_set,
  input logic              cp_doorbell_ack,
  input logic              cp_run,
  input logic              cp_bypass,
  input logic              cp_doorbell,
  input logic              host_irq
);
  logic ctrl_wr;
  assign ctrl_wr = hb_valid && hb_we && (hb_reg == 2'd3);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!cp_run && !cp_bypass && !cp_doorbell && !host_irq));

  assert_run_follows_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (cp_run == $past(hb_wdata[0]) && cp_bypass == $past(hb_wdata[2])));

  assert_dbell_set_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && hb_wdata[3]) |=> cp_doorbell);

  assert_dbell_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (cp_doorbell && !cp_doorbell_ack) |=> cp_doorbell);

  assert_cause_raise_R8: assert property (@(posedge clk) disable iff (rst)
    (cp_int0_set || cp_int1_set) |=> host_irq);

  assert_irq_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
    (!host_irq && !cp_int0_set && !cp_int1_set) |=> !host_irq);
endmodule

bind shram_host_port shram_host_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .hb_valid        (hb_valid),
  .hb_we           (hb_we),
  .hb_reg          (hb_reg),
  .hb_wdata        (hb_wdata),
  .cp_int0_set     (cp_int0_set),
  .cp_int1_set     (cp_int1_set),
  .cp_doorbell_ack (cp_doorbell_ack),
  .cp_run          (cp_run),
  .cp_bypass       (cp_bypass),
  .cp_doorbell     (cp_doorbell),
  .host_irq        (host_irq)
);

// File: tb/shram_host_port_tb.sv
module shram_host_port_tb;
  localparam int DW = 8;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hb_valid = 1'b0;
  logic          hb_we = 1'b0;
  logic [1:0]    hb_reg = 2'd0;
  logic [DW-1:0] hb_wdata = '0;
  logic [DW-1:0] hb_rdata;
  logic          cp_int0_set = 1'b0;
  logic          cp_int1_set = 1'b0;
  logic          cp_doorbell_ack = 1'b0;
  logic          cp_run, cp_bypass, cp_doorbell, host_irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  shram_host_port #(.DATA_W(DW), .RAM_AW(AW)) u_dut (
    .clk(clk), .rst(rst), .hb_valid(hb_valid), .hb_we(hb_we), .hb_reg(hb_reg),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .cp_int0_set(cp_int0_set),
    .cp_int1_set(cp_int1_set), .cp_doorbell_ack(cp_doorbell_ack), .cp_run(cp_run),
    .cp_bypass(cp_bypass), .cp_doorbell(cp_doorbell), .host_irq(host_irq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] r, input logic [DW-1:0] d);
    @(negedge clk);
    hb_valid = 1'b1; hb_we = 1'b1; hb_reg = r; hb_wdata = d;
    @(negedge clk);
    hb_valid = 1'b0; hb_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] r, output logic [DW-1:0] d);
    @(negedge clk);
    hb_valid = 1'b1; hb_we = 1'b0; hb_reg = r;
    @(negedge clk);
    hb_valid = 1'b0;
    d = hb_rdata;
  endtask

  task automatic set_ptr(input logic [15:0] a);
    bus_wr(2'd0, a[7:0]);
    bus_wr(2'd1, a[15:8]);
  endtask

  task automatic rd_ptr(output logic [15:0] a);
    logic [DW-1:0] lo, hi;
    bus_rd(2'd0, lo);
    bus_rd(2'd1, hi);
    a = {hi, lo};
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [15:0]   a;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 outputs", {12'd0, cp_run, cp_bypass, cp_doorbell, host_irq}, 16'd0);
    bus_rd(2'd3, d); chk("R1 ctrl", {8'd0, d}, 16'd0);
    rd_ptr(a);       chk("R1 ptr", a, 16'h0000);

    // R2 split pointer bytes
    set_ptr(16'h1234);
    rd_ptr(a); chk("R2 ptr load", a, 16'h1234);
    bus_wr(2'd1, 8'h56);
    rd_ptr(a); chk("R2 hi keeps lo", a, 16'h5634);
    bus_wr(2'd0, 8'h9A);
    rd_ptr(a); chk("R2 lo keeps hi", a, 16'h569A);

    // R6 control layout and outputs
    bus_wr(2'd3, 8'h07);
    chk("R6 run/bypass on", {14'd0, cp_run, cp_bypass}, 16'h3);
    bus_rd(2'd3, d); chk("R6 ctrl readback", {8'd0, d}, 16'h0007);
    bus_wr(2'd3, 8'hC1);
    bus_rd(2'd3, d); chk("R6 upper bits ignored", {8'd0, d}, 16'h0001);
    chk("R6 bypass off", {15'd0, cp_bypass}, 16'h0);

    // R3 and R4 single accesses, streaming off
    for (int i = 0; i < 16; i++) begin
      set_ptr(16'((i * 67) & 16'h03FF));
      bus_wr(2'd2, pat(i));
      rd_ptr(a); chk("R4 no step on write", a, 16'((i * 67) & 16'h03FF));
    end
    for (int i = 15; i >= 0; i--) begin
      set_ptr(16'((i * 67) & 16'h03FF));
      bus_rd(2'd2, d); chk("R3 single readback", {8'd0, d}, {8'd0, pat(i)});
      rd_ptr(a); chk("R4 no step on read", a, 16'((i * 67) & 16'h03FF));
    end

    // R4 streamed block
    bus_wr(2'd3, 8'h03);
    set_ptr(16'h0100);
    for (int i = 0; i < 64; i++) bus_wr(2'd2, pat(i + 100));
    rd_ptr(a); chk("R4 stream write step", a, 16'h0140);
    set_ptr(16'h0100);
    for (int i = 0; i < 64; i++) begin
      bus_rd(2'd2, d); chk("R4 stream readback", {8'd0, d}, {8'd0, pat(i + 100)});
    end
    rd_ptr(a); chk("R4 stream read step", a, 16'h0140);

    // R2 aliasing above RAM_AW
    bus_wr(2'd3, 8'h01);
    set_ptr(16'h0405);
    bus_wr(2'd2, 8'h3C);
    set_ptr(16'h0005);
    bus_rd(2'd2, d); chk("R2 low-bit alias", {8'd0, d}, 16'h003C);

    // R5 wrap
    bus_wr(2'd3, 8'h03);
    set_ptr(16'hFFFF);
    bus_wr(2'd2, 8'hA5);
    rd_ptr(a); chk("R5 wrap to zero", a, 16'h0000);
    set_ptr(16'h03FF);
    bus_rd(2'd2, d); chk("R5 byte at wrap", {8'd0, d}, 16'h00A5);

    // R7 doorbell
    bus_wr(2'd3, 8'h0B);
    chk("R7 doorbell set", {15'd0, cp_doorbell}, 16'h1);
    bus_wr(2'd3, 8'h03);
    chk("R7 zero write keeps", {15'd0, cp_doorbell}, 16'h1);
    bus_rd(2'd3, d); chk("R7 readback", {8'd0, d}, 16'h000B);
    @(negedge clk); cp_doorbell_ack = 1'b1;
    @(negedge clk); cp_doorbell_ack = 1'b0;
    chk("R7 ack clears", {15'd0, cp_doorbell}, 16'h0);
    @(negedge clk);
    cp_doorbell_ack = 1'b1; hb_valid = 1'b1; hb_we = 1'b1; hb_reg = 2'd3; hb_wdata = 8'h0B;
    @(negedge clk);
    cp_doorbell_ack = 1'b0; hb_valid = 1'b0; hb_we = 1'b0;
    chk("R7 set beats ack", {15'd0, cp_doorbell}, 16'h1);
    @(negedge clk); cp_doorbell_ack = 1'b1;
    @(negedge clk); cp_doorbell_ack = 1'b0;

    // R8 causes and shared line
    @(negedge clk); cp_int0_set = 1'b1;
    @(negedge clk); cp_int0_set = 1'b0;
    chk("R8 cause A irq", {15'd0, host_irq}, 16'h1);
    bus_rd(2'd3, d); chk("R8 cause A bit", {8'd0, d}, 16'h0013);
    @(negedge clk); cp_int1_set = 1'b1;
    @(negedge clk); cp_int1_set = 1'b0;
    bus_rd(2'd3, d); chk("R8 both causes", {8'd0, d}, 16'h0033);

    // R9 write-one-to-clear
    bus_wr(2'd3, 8'h13);
    bus_rd(2'd3, d); chk("R9 clear A only", {8'd0, d}, 16'h0023);
    chk("R9 irq still high", {15'd0, host_irq}, 16'h1);
    bus_wr(2'd3, 8'h03);
    bus_rd(2'd3, d); chk("R9 zero keeps B", {8'd0, d}, 16'h0023);
    bus_wr(2'd3, 8'h23);
    chk("R9 irq low", {15'd0, host_irq}, 16'h0);
    @(negedge clk);
    cp_int0_set = 1'b1; hb_valid = 1'b1; hb_we = 1'b1; hb_reg = 2'd3; hb_wdata = 8'h13;
    @(negedge clk);
    cp_int0_set = 1'b0; hb_valid = 1'b0; hb_we = 1'b0;
    bus_rd(2'd3, d); chk("R9 set beats clear", {8'd0, d}, 16'h0013);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule